// File: doc/BRIEF.md
# Four-Function ALU with Packed Condition Flags

This block is a purely combinational arithmetic and logic unit for a 16-bit datapath. It takes two operand words and a 2-bit operation select, and returns the 16-bit result of an addition, a subtraction, a bitwise AND or a bitwise OR. It also returns a 16-bit status word that carries four condition bits in its lowest positions: zero, negative, carry and signed overflow.

On a subtraction the carry bit signals an unsigned borrow, so it is set when the first operand is smaller than the second. This is the opposite of the inverted-carry convention, and software tests for "below" directly on this bit. The two logic operations clear both carry and overflow. The surrounding datapath picks the operands and decides whether the status word is stored. This block only computes the status word.

Top module: `alu_nzcv`

## Requirements
- R1: With op_i = 2'b00 the result equals a_i + b_i modulo 2^16.
- R2: With op_i = 2'b01 the result equals a_i - b_i modulo 2^16.
- R3: With op_i = 2'b10 the result equals a_i & b_i, and with op_i = 2'b11 it equals a_i | b_i.
- R4: Flag bit 0 (Z) is 1 exactly when the 16-bit result is all zeros, for every operation.
- R5: Flag bit 1 (N) equals bit 15 of the result, for every operation.
- R6: For addition, flag bit 2 (C) is 1 exactly when the unsigned sum exceeds 16'hFFFF.
- R7: For subtraction, flag bit 2 (C) is 1 exactly when a_i < b_i as unsigned numbers (a borrow).
- R8: For addition and subtraction, flag bit 3 (V) is 1 exactly when the exact signed result of the two's-complement operands lies outside -32768..32767.
- R9: For AND and OR, flag bits 2 (C) and 3 (V) are both 0.
- R10: Flag bits 15 down to 4 are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand (the minuend for subtraction) |
| b_i | input | 16 | Second operand (the subtrahend for subtraction) |
| op_i | input | 2 | Operation: 00 add, 01 subtract, 10 AND, 11 OR |
| result_o | output | 16 | Operation result |
| flags_o | output | 16 | Status word: bit 3 V, bit 2 C, bit 1 N, bit 0 Z, other bits zero |

## Verification
The bench aims at the borrow convention:
- 5 - 5 must leave C clear.
- 0 - 1 must set C.

A design that used the inverted-carry convention would fail both cases.

For overflow, the bench uses several operand pairs:
- 7FFF + 1 and 8000 + 8000 check addition.
- 8000 - 1 and 7FFF - FFFF check subtraction, which can overflow when the signs differ.

A design that reused the addition sign rule for subtraction would miss these cases.

Logic operations are driven with operands whose sum would carry. A unit that left the adder's carry or overflow on the flags during AND or OR would show nonzero C or V there. Wrap-around to zero checks that Z follows the truncated result and not the 17-bit sum.

// File: rtl/alu_nzcv_pkg.sv
package alu_nzcv_pkg;

  typedef enum logic [1:0] {
    ALU_ADD = 2'b00,
    ALU_SUB = 2'b01,
    ALU_AND = 2'b10,
    ALU_OR  = 2'b11
  } alu_op_e;

  // positions of the condition bits inside the status word
  localparam int FLG_Z     = 0;
  localparam int FLG_N     = 1;
  localparam int FLG_C     = 2;
  localparam int FLG_V     = 3;
  localparam int FLG_COUNT = 4;

  // arithmetic ops have the high select bit clear
  function automatic logic op_is_arith(input logic [1:0] op);
    return ~op[1];
  endfunction

  // subtract is the arithmetic op with the low bit set
  function automatic logic op_is_sub(input logic [1:0] op);
    return ~op[1] & op[0];
  endfunction

  // bitwise logic ops choose OR when the low bit is set
  function automatic logic op_is_or(input logic [1:0] op);
    return op[1] & op[0];
  endfunction

endpackage

// File: rtl/alu_nzcv_addsub.sv
module alu_nzcv_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         ovf_o
);

  logic [W-1:0] b_eff;
  logic [W:0]   full_sum;
  logic [W-1:0] low_sum;
  logic         carry_into_msb;
  logic         raw_cout;
  logic         borrow;

  always_comb begin
    b_eff    = sub_i ? ~b_i : b_i;
    full_sum = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
    low_sum  = {1'b0, a_i[W-2:0]} + {1'b0, b_eff[W-2:0]} + {{(W-1){1'b0}}, sub_i};
  end

  assign carry_into_msb = low_sum[W-1];
  assign raw_cout       = full_sum[W];
  assign sum_o          = full_sum[W-1:0];
  // a subtraction with no carry out of the inverted add has borrowed
  assign borrow         = sub_i & ~raw_cout;
  assign carry_o        = sub_i ? borrow : raw_cout;
  // overflow from the carries around the sign bit
  assign ovf_o          = carry_into_msb ^ raw_cout;

  always_comb begin
    if (sub_i) begin
      AST_SUB_BORROW: assert (carry_o == (a_i < b_i))
        else $error("borrow flag disagrees with unsigned compare"); // R7
    end else begin
      AST_ADD_CARRY: assert (carry_o == (sum_o < a_i))
        else $error("carry flag disagrees with wrapped sum"); // R6
    end
    AST_OVF_SIGN: assert (ovf_o == ((a_i[W-1] == (b_i[W-1] ^ sub_i)) && (sum_o[W-1] != a_i[W-1])))
      else $error("overflow flag disagrees with operand signs"); // R8
  end

endmodule

// File: rtl/alu_nzcv_logic.sv
module alu_nzcv_logic #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         or_i,
  output logic [W-1:0] y_o
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign y_o[i] = or_i ? (a_i[i] | b_i[i]) : (a_i[i] & b_i[i]);
  end

  always_comb begin
    AST_LOGIC_BOUND: assert (or_i ? ((y_o & ~(a_i | b_i)) == '0) : ((y_o & ~(a_i & b_i)) == '0))
      else $error("logic result has a bit outside its operands"); // R3
  end

endmodule

// File: rtl/alu_nzcv_flags.sv
module alu_nzcv_flags
  import alu_nzcv_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FLAG_W = 16
) (
  input  logic [DATA_W-1:0] result_i,
  input  logic              carry_i,
  input  logic              ovf_i,
  input  logic              arith_i,
  output logic [FLAG_W-1:0] flags_o
);

  logic zero_w;
  logic neg_w;

  assign zero_w = ~|result_i;
  assign neg_w  = result_i[DATA_W-1];

  always_comb begin
    flags_o        = '0;
    flags_o[FLG_Z] = zero_w;
    flags_o[FLG_N] = neg_w;
    flags_o[FLG_C] = arith_i & carry_i;
    flags_o[FLG_V] = arith_i & ovf_i;
  end

endmodule

// File: rtl/alu_nzcv.sv
module alu_nzcv
  import alu_nzcv_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FLAG_W = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [1:0]        op_i,
  output logic [DATA_W-1:0] result_o,
  output logic [FLAG_W-1:0] flags_o
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] arith_y;
  logic [DATA_W-1:0] logic_y;
  logic              arith_carry;
  logic              arith_ovf;
  logic              is_arith;
  logic              is_sub;
  logic              is_or;

  assign is_arith = op_is_arith(op_i);
  assign is_sub   = op_is_sub(op_i);
  assign is_or    = op_is_or(op_i);

  alu_nzcv_addsub #(.W(DATA_W)) u_addsub (
    .a_i    (a_i),
    .b_i    (b_i),
    .sub_i  (is_sub),
    .sum_o  (arith_y),
    .carry_o(arith_carry),
    .ovf_o  (arith_ovf)
  );

  alu_nzcv_logic #(.W(DATA_W)) u_logic (
    .a_i (a_i),
    .b_i (b_i),
    .or_i(is_or),
    .y_o (logic_y)
  );

  assign result_o = is_arith ? arith_y : logic_y;

  alu_nzcv_flags #(.DATA_W(DATA_W), .FLAG_W(FLAG_W)) u_flags (
    .result_i(result_o),
    .carry_i (arith_carry),
    .ovf_i   (arith_ovf),
    .arith_i (is_arith),
    .flags_o (flags_o)
  );

  always_comb begin
    if (!is_arith) begin
      AST_LOGIC_CLEAR: assert (flags_o[FLG_C] == 1'b0 && flags_o[FLG_V] == 1'b0)
        else $error("carry or overflow left set by a logic op"); // R9
    end
    AST_UPPER_ZERO: assert ((flags_o >> FLG_COUNT) == '0)
      else $error("unused status bits not zero"); // R10
    AST_NEG_SIGN: assert (flags_o[FLG_N] == (is_arith ? arith_y[MSB] : logic_y[MSB]))
      else $error("negative flag does not follow the selected sign bit"); // R5
  end

endmodule

// File: tb/tb_alu_nzcv.sv
module tb_alu_nzcv;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] a = '0;
  logic [15:0] b = '0;
  logic [1:0]  op = '0;
  logic [15:0] res;
  logic [15:0] flg;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  alu_nzcv dut (
    .a_i     (a),
    .b_i     (b),
    .op_i    (op),
    .result_o(res),
    .flags_o (flg)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s a=%h b=%h op=%0d actual=%h expected=%h", tag, a, b, op, act, exp);
    end
  endtask

  // behavioural reference built on plain integers
  task automatic model(input int ai, input int bi, input int o,
                       output int r, output int z, output int n, output int c, output int v);
    int sa, sb, exact;
    sa = (ai >= 32768) ? ai - 65536 : ai;
    sb = (bi >= 32768) ? bi - 65536 : bi;
    c = 0; v = 0;
    case (o)
      0: begin exact = sa + sb; r = (ai + bi) % 65536; c = (ai + bi > 65535) ? 1 : 0; end
      1: begin exact = sa - sb; r = (ai - bi + 65536) % 65536; c = (ai < bi) ? 1 : 0; end
      2: begin exact = 0; r = ai & bi; end
      default: begin exact = 0; r = ai | bi; end
    endcase
    if (o < 2) v = (exact > 32767 || exact < -32768) ? 1 : 0;
    z = (r == 0) ? 1 : 0;
    n = (r >= 32768) ? 1 : 0;
  endtask

  task automatic apply(input int ai, input int bi, input int o);
    int r, z, n, c, v;
    @(posedge clk);
    #1;
    a = ai[15:0]; b = bi[15:0]; op = o[1:0];
    @(negedge clk);
    model(ai, bi, o, r, z, n, c, v);
    case (o)
      0: check("R1 sum", int'(res), r);
      1: check("R2 difference", int'(res), r);
      default: check("R3 logic result", int'(res), r);
    endcase
    check("R4 Z flag", int'(flg[0]), z);
    check("R5 N flag", int'(flg[1]), n);
    if (o == 0) check("R6 add carry", int'(flg[2]), c);
    else if (o == 1) check("R7 sub borrow", int'(flg[2]), c);
    else check("R9 logic C clear", int'(flg[2]), 0);
    if (o < 2) check("R8 overflow", int'(flg[3]), v);
    else check("R9 logic V clear", int'(flg[3]), 0);
    check("R10 upper bits", int'(flg[15:4]), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // held at zero operands through reset: add gives zero result with Z set
    check("R4 reset Z", int'(flg[0]), 1);
    check("R1 reset result", int'(res), 0);
    rst_n = 1'b1;

    for (int o = 0; o < 4; o++) apply(0, 0, o);
    apply(16'hFFFF, 1, 0);          // wrap to zero, carry
    apply(16'h7FFF, 1, 0);          // positive overflow
    apply(16'h8000, 16'h8000, 0);   // carry, overflow, zero
    apply(16'h1234, 16'h4321, 0);
    apply(5, 5, 1);                 // equal: no borrow
    apply(0, 1, 1);                 // borrow, negative
    apply(16'h8000, 1, 1);          // signed overflow on subtract
    apply(16'h7FFF, 16'hFFFF, 1);   // overflow and borrow
    apply(16'hFFFF, 16'h0001, 1);
    apply(16'hFFFF, 16'hFFFF, 2);
    apply(16'hF0F0, 16'h0F0F, 2);   // AND to zero
    apply(16'hF0F0, 16'h0F0F, 3);
    apply(16'h8000, 16'h8000, 3);   // would carry if added
    apply(16'hFFFF, 16'hFFFF, 3);

    for (int i = 0; i < 400; i++) begin
      int av, bv;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      av = int'(lfsr);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      bv = int'(lfsr);
      apply(av, bv, i % 4);
    end
    finish_run();
  end

endmodule